// File: doc/BRIEF.md
# Multi-Lane In-Place Compare-Exchange Kernel

This block holds one slice of a larger sort in a small local store of 2^m words and runs a list of compare-exchange passes over it using k lanes in parallel. Software-side control is minimal. The surrounding logic fills the store through a load port, supplies a list of m bit positions and a direction bit for every pair slot, and pulses start. The kernel then works through the position list in order. For each entry it compare-exchanges all 2^(m-1) word pairs whose addresses differ only in that bit. When the last pass is done it pulses done, and the caller reads the words back through a combinational read port.

Pair addresses come from a pair counter j. The lower address is j with a 0 inserted at the selected bit, and the upper address is j with a 1 inserted there. Lane l takes the counters l, l+k, l+2k and so on, one per cycle. All k lanes therefore finish a pass together, and the next list entry starts on the following cycle. Every lane reads and writes both of its words in every busy cycle, whether or not they are swapped. The cycle count of a run therefore never depends on the data.

Top module: `cx_kernel`

## Requirements
- R1: After synchronous reset, busy and done are low and every stored word reads as zero.
- R2: While idle, a cycle with ld_en high writes ld_data to word ld_addr. rd_data always shows word rd_addr combinationally.
- R3: start sampled while idle captures gamma_list and dir_bits; later changes to those inputs have no effect on the run. busy is then high for exactly m·2^(m-1)/k cycles. done is high for exactly one cycle, which is the first cycle in which busy is low again.
- R4: Pass i, for i = 0 to m-1 in that order, uses the bit position held in gamma_list[i·PW +: PW], where PW = clog2(m). Every entry must be below m, and entries may repeat.
- R5: For pair counter j and position c, the lower address is j with a 0 inserted at bit c and the upper address is j with a 1 inserted at bit c. For example, j = 7 and c = 1 give words 13 and 15.
- R6: When dir_bits[j] = 0, the pair ends with the smaller word at the lower address. When dir_bits[j] = 1, the larger word goes to the lower address. Equal words stay as they are.
- R7: Lane l handles pair counters l, l+k, l+2k, and so on. In every busy cycle the 2k addresses touched by the lanes are all distinct, so every pair of a pass is exchanged exactly once.
- R8: While busy, ld_en and start have no effect on the stored words or on the run length. While idle without ld_en, the stored words do not change.
- R9: A bitonic sequence run with the positions m-1, m-2, …, 0 and all direction bits 0 comes out sorted in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write one word while idle |
| ld_addr | input | LOG_WORDS | Word address for a load |
| ld_data | input | DATA_W | Word value for a load |
| rd_addr | input | LOG_WORDS | Word address for reading |
| rd_data | output | DATA_W | Word at rd_addr (combinational) |
| start | input | 1 | Begin a run (honoured only while idle) |
| gamma_list | input | LOG_WORDS·PW | Packed list of m bit positions, entry 0 in the low field |
| dir_bits | input | 2^(LOG_WORDS-1) | Per pair counter order: 0 ascending, 1 descending |
| busy | output | 1 | High while passes run |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The bench uses the default build: 16 words of 8 bits, 2 lanes, and 4 passes of 4 cycles each. With this size, all 256 possible position lists (every ordering, with and without repeats) can be swept, each paired with its own direction pattern and fresh data, and every word of every result is compared against an arithmetic model. The small store also allows directed checks of the worked insert example (pair 7 at bit 1 touching words 13 and 15), of a full bitonic merge, and of loads and starts issued in the middle of a run.

// File: rtl/cxk_pkg.sv
package cxk_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } cxk_state_e;

    typedef enum logic {
        ORD_UP   = 1'b0,
        ORD_DOWN = 1'b1
    } cxk_order_e;

    typedef struct packed {
        logic swap;
        logic equal;
    } cxk_verdict_t;

    // Width needed to index n items (at least one bit).
    function automatic int unsigned bits_for(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Open a gap at bit 'pos' of 'val' and place 'b' in it.
    function automatic int unsigned insert_bit(input int unsigned val,
                                               input logic        b,
                                               input int unsigned pos);
        int unsigned keep_low;
        keep_low = (32'd1 << pos) - 32'd1;
        return ((val & ~keep_low) << 1) | (32'(b) << pos) | (val & keep_low);
    endfunction

endpackage

// File: rtl/cxk_seq.sv
module cxk_seq
    import cxk_pkg::*;
#(
    parameter  int unsigned LOG_WORDS = 4,
    parameter  int unsigned LOG_LANES = 1,
    localparam int unsigned PAIRS     = 1 << (LOG_WORDS - 1),
    localparam int unsigned LANES     = 1 << LOG_LANES,
    localparam int unsigned STEPS     = PAIRS / LANES,
    localparam int unsigned STEP_W    = bits_for(STEPS),
    localparam int unsigned POS_W     = bits_for(LOG_WORDS),
    localparam int unsigned LIST_W    = LOG_WORDS * POS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LIST_W-1:0] gamma_in,
    input  logic [PAIRS-1:0]  dir_in,
    output logic              busy,
    output logic              done,
    output logic [STEP_W-1:0] step,
    output logic [POS_W-1:0]  pos,
    output logic [PAIRS-1:0]  dir_q
);

    cxk_state_e        state_q;
    logic [POS_W-1:0]  pass_q;
    logic [STEP_W-1:0] step_q;
    logic [LIST_W-1:0] gamma_q;
    logic              last_step;
    logic              last_pass;

    assign last_step = (step_q == STEP_W'(STEPS - 1));
    assign last_pass = (pass_q == POS_W'(LOG_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pass_q  <= '0;
            step_q  <= '0;
            gamma_q <= '0;
            dir_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        gamma_q <= gamma_in;
                        dir_q   <= dir_in;
                        pass_q  <= '0;
                        step_q  <= '0;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (last_step) begin
                        step_q <= '0;
                        if (last_pass) begin
                            state_q <= ST_IDLE;
                            done    <= 1'b1;
                        end else begin
                            pass_q <= pass_q + POS_W'(1);
                        end
                    end else begin
                        step_q <= step_q + STEP_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q == ST_RUN);
    assign step = step_q;
    assign pos  = gamma_q[int'(pass_q) * POS_W +: POS_W];

endmodule

// File: rtl/cxk_lane.sv
module cxk_lane
    import cxk_pkg::*;
#(
    parameter  int unsigned LOG_WORDS = 4,
    parameter  int unsigned LOG_LANES = 1,
    parameter  int unsigned LANE      = 0,
    localparam int unsigned PAIRS     = 1 << (LOG_WORDS - 1),
    localparam int unsigned LANES     = 1 << LOG_LANES,
    localparam int unsigned STEPS     = PAIRS / LANES,
    localparam int unsigned STEP_W    = bits_for(STEPS),
    localparam int unsigned POS_W     = bits_for(LOG_WORDS),
    localparam int unsigned PAIR_W    = bits_for(PAIRS),
    localparam int unsigned ADDR_W    = LOG_WORDS
) (
    input  logic [STEP_W-1:0] step,
    input  logic [POS_W-1:0]  pos,
    input  logic [PAIRS-1:0]  dir_q,
    output logic [ADDR_W-1:0] lo_addr,
    output logic [ADDR_W-1:0] hi_addr,
    output cxk_order_e        order
);

    // Pair counter for this lane in this cycle: LANE + LANES * step.
    always_comb begin
        lo_addr = ADDR_W'(insert_bit(32'(step) * LANES + LANE, 1'b0, 32'(pos)));
        hi_addr = ADDR_W'(insert_bit(32'(step) * LANES + LANE, 1'b1, 32'(pos)));
        order   = cxk_order_e'(dir_q[PAIR_W'(32'(step) * LANES + LANE)]);
    end

endmodule

// File: rtl/cxk_cmpx.sv
module cxk_cmpx
    import cxk_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] lo_in,
    input  logic [DATA_W-1:0] hi_in,
    input  cxk_order_e        order,
    output logic [DATA_W-1:0] lo_out,
    output logic [DATA_W-1:0] hi_out
);

    cxk_verdict_t verdict;

    // Both words are always produced; only the mux select depends on data.
    always_comb begin
        verdict.equal = (lo_in == hi_in);
        verdict.swap  = (order == ORD_UP) ? (lo_in > hi_in) : (lo_in < hi_in);
        lo_out = verdict.swap ? hi_in : lo_in;
        hi_out = verdict.swap ? lo_in : hi_in;
    end

endmodule

// File: rtl/cxk_store.sv
module cxk_store #(
    parameter  int unsigned DATA_W = 8,
    parameter  int unsigned ADDR_W = 4,
    parameter  int unsigned LANES  = 2,
    localparam int unsigned WORDS  = 1 << ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ld_en,
    input  logic [ADDR_W-1:0]       ld_addr,
    input  logic [DATA_W-1:0]       ld_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data,
    input  logic                    xch_en,
    input  logic [ADDR_W-1:0]       lo_addr [LANES],
    input  logic [ADDR_W-1:0]       hi_addr [LANES],
    output logic [DATA_W-1:0]       lo_rd   [LANES],
    output logic [DATA_W-1:0]       hi_rd   [LANES],
    input  logic [DATA_W-1:0]       lo_wr   [LANES],
    input  logic [DATA_W-1:0]       hi_wr   [LANES],
    output logic [WORDS*DATA_W-1:0] snap
);

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '0;
        end else if (xch_en) begin
            for (int l = 0; l < LANES; l++) begin
                mem[lo_addr[l]] <= lo_wr[l];
                mem[hi_addr[l]] <= hi_wr[l];
            end
        end else if (ld_en) begin
            mem[ld_addr] <= ld_data;
        end
    end

    assign rd_data = mem[rd_addr];

    for (genvar l = 0; l < LANES; l++) begin : g_port
        assign lo_rd[l] = mem[lo_addr[l]];
        assign hi_rd[l] = mem[hi_addr[l]];
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_snap
        assign snap[w*DATA_W +: DATA_W] = mem[w];
    end

endmodule

// File: rtl/cx_kernel.sv
module cx_kernel
    import cxk_pkg::*;
#(
    parameter  int unsigned LOG_WORDS = 4,
    parameter  int unsigned LOG_LANES = 1,
    parameter  int unsigned DATA_W    = 8,
    localparam int unsigned PAIRS     = 1 << (LOG_WORDS - 1),
    localparam int unsigned WORDS     = 1 << LOG_WORDS,
    localparam int unsigned LANES     = 1 << LOG_LANES,
    localparam int unsigned STEPS     = PAIRS / LANES,
    localparam int unsigned STEP_W    = bits_for(STEPS),
    localparam int unsigned POS_W     = bits_for(LOG_WORDS),
    localparam int unsigned LIST_W    = LOG_WORDS * POS_W,
    localparam int unsigned ADDR_W    = LOG_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              start,
    input  logic [LIST_W-1:0] gamma_list,
    input  logic [PAIRS-1:0]  dir_bits,
    output logic              busy,
    output logic              done
);

    logic [STEP_W-1:0]       step;
    logic [POS_W-1:0]        pos;
    logic [PAIRS-1:0]        dir_q;
    logic [ADDR_W-1:0]       lo_a  [LANES];
    logic [ADDR_W-1:0]       hi_a  [LANES];
    logic [DATA_W-1:0]       lo_rd [LANES];
    logic [DATA_W-1:0]       hi_rd [LANES];
    logic [DATA_W-1:0]       lo_wr [LANES];
    logic [DATA_W-1:0]       hi_wr [LANES];
    cxk_order_e              order [LANES];
    logic [LANES*ADDR_W-1:0] lo_flat;
    logic [LANES*ADDR_W-1:0] hi_flat;
    logic [WORDS*DATA_W-1:0] snap;

    cxk_seq #(
        .LOG_WORDS(LOG_WORDS),
        .LOG_LANES(LOG_LANES)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .gamma_in(gamma_list),
        .dir_in  (dir_bits),
        .busy    (busy),
        .done    (done),
        .step    (step),
        .pos     (pos),
        .dir_q   (dir_q)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        cxk_lane #(
            .LOG_WORDS(LOG_WORDS),
            .LOG_LANES(LOG_LANES),
            .LANE     (l)
        ) u_lane (
            .step   (step),
            .pos    (pos),
            .dir_q  (dir_q),
            .lo_addr(lo_a[l]),
            .hi_addr(hi_a[l]),
            .order  (order[l])
        );

        cxk_cmpx #(
            .DATA_W(DATA_W)
        ) u_cmpx (
            .lo_in (lo_rd[l]),
            .hi_in (hi_rd[l]),
            .order (order[l]),
            .lo_out(lo_wr[l]),
            .hi_out(hi_wr[l])
        );

        assign lo_flat[l*ADDR_W +: ADDR_W] = lo_a[l];
        assign hi_flat[l*ADDR_W +: ADDR_W] = hi_a[l];
    end

    cxk_store #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W),
        .LANES (LANES)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .ld_en  (ld_en),
        .ld_addr(ld_addr),
        .ld_data(ld_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .xch_en (busy),
        .lo_addr(lo_a),
        .hi_addr(hi_a),
        .lo_rd  (lo_rd),
        .hi_rd  (hi_rd),
        .lo_wr  (lo_wr),
        .hi_wr  (hi_wr),
        .snap   (snap)
    );

endmodule

// File: rtl/cxk_checker.sv
module cxk_checker
    import cxk_pkg::*;
#(
    parameter  int unsigned LOG_WORDS = 4,
    parameter  int unsigned LOG_LANES = 1,
    parameter  int unsigned DATA_W    = 8,
    localparam int unsigned PAIRS     = 1 << (LOG_WORDS - 1),
    localparam int unsigned WORDS     = 1 << LOG_WORDS,
    localparam int unsigned LANES     = 1 << LOG_LANES,
    localparam int unsigned TOTAL     = LOG_WORDS * (PAIRS / LANES),
    localparam int unsigned POS_W     = bits_for(LOG_WORDS),
    localparam int unsigned LIST_W    = LOG_WORDS * POS_W,
    localparam int unsigned ADDR_W    = LOG_WORDS
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start,
    input logic                    ld_en,
    input logic                    busy,
    input logic                    done,
    input logic [LIST_W-1:0]       gamma_list,
    input logic [POS_W-1:0]        pos,
    input logic [LANES*ADDR_W-1:0] lo_flat,
    input logic [LANES*ADDR_W-1:0] hi_flat,
    input logic [WORDS*DATA_W-1:0] snap
);

    logic [31:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst)       run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + 32'd1;
        else           run_cnt <= '0;
    end

    function automatic logic all_distinct(input logic [LANES*ADDR_W-1:0] lo,
                                          input logic [LANES*ADDR_W-1:0] hi);
        logic [2*LANES*ADDR_W-1:0] both;
        logic ok;
        both = {hi, lo};
        ok   = 1'b1;
        for (int a = 0; a < 2 * LANES; a++)
            for (int b = a + 1; b < 2 * LANES; b++)
                if (both[a*ADDR_W +: ADDR_W] == both[b*ADDR_W +: ADDR_W]) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic list_in_range(input logic [LIST_W-1:0] lst);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < LOG_WORDS; i++)
            if (32'(lst[i*POS_W +: POS_W]) >= LOG_WORDS) ok = 1'b0;
        return ok;
    endfunction

    p_start_runs_r3: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_at_fall_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_run_length_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_cnt == TOTAL));

    p_list_range_r4: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |-> list_in_range(gamma_list));

    for (genvar l = 0; l < LANES; l++) begin : g_pair_chk
        p_pair_bit_r5: assert property (@(posedge clk) disable iff (rst)
            busy |-> (((lo_flat[l*ADDR_W +: ADDR_W] ^ hi_flat[l*ADDR_W +: ADDR_W])
                       == (ADDR_W'(1) << pos))
                      && !lo_flat[l*ADDR_W + int'(pos)]));
    end

    p_lanes_distinct_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> all_distinct(lo_flat, hi_flat));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !ld_en) |=> $stable(snap));

endmodule

bind cx_kernel cxk_checker #(
    .LOG_WORDS(LOG_WORDS),
    .LOG_LANES(LOG_LANES),
    .DATA_W   (DATA_W)
) u_cxk_checker (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .ld_en     (ld_en),
    .busy      (busy),
    .done      (done),
    .gamma_list(gamma_list),
    .pos       (pos),
    .lo_flat   (lo_flat),
    .hi_flat   (hi_flat),
    .snap      (snap)
);

// File: tb/cx_kernel_bench.sv
module cx_kernel_bench;

    localparam int LOG_WORDS = 4;
    localparam int LOG_LANES = 1;
    localparam int DATA_W    = 8;
    localparam int WORDS     = 16;
    localparam int PAIRS     = 8;
    localparam int RUN_CYC   = 16;   // 4 passes x 8 pairs / 2 lanes

    logic       clk = 1'b0;
    logic       rst;
    logic       ld_en;
    logic [3:0] ld_addr;
    logic [7:0] ld_data;
    logic [3:0] rd_addr;
    logic [7:0] rd_data;
    logic       start;
    logic [7:0] gamma_list;
    logic [7:0] dir_bits;
    logic       busy;
    logic       done;

    int checks = 0;
    int fails  = 0;
    logic [7:0]  model [WORDS];
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    cx_kernel #(
        .LOG_WORDS(LOG_WORDS),
        .LOG_LANES(LOG_LANES),
        .DATA_W   (DATA_W)
    ) u_cx_kernel (
        .clk       (clk),
        .rst       (rst),
        .ld_en     (ld_en),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .start     (start),
        .gamma_list(gamma_list),
        .dir_bits  (dir_bits),
        .busy      (busy),
        .done      (done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[7:0];
    endfunction

    task automatic load_word(input int a, input logic [7:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = 4'(a); ld_data = v;
        @(negedge clk);
        ld_en = 1'b0;
        model[a] = v;
    endtask

    task automatic read_word(input int a, output logic [7:0] v);
        rd_addr = 4'(a);
        #1;
        v = rd_data;
    endtask

    // Reference: passes in list order, every pair exchanged once per pass.
    task automatic model_run(input logic [7:0] g, input logic [7:0] d);
        for (int i = 0; i < LOG_WORDS; i++) begin
            int c;
            c = int'(g[i*2 +: 2]);
            for (int j = 0; j < PAIRS; j++) begin
                int lo, hi;
                logic [7:0] t;
                lo = ((j >> c) << (c + 1)) | (j & ((1 << c) - 1));
                hi = lo + (1 << c);
                if (d[j] ? (model[lo] < model[hi]) : (model[lo] > model[hi])) begin
                    t = model[lo]; model[lo] = model[hi]; model[hi] = t;
                end
            end
        end
    endtask

    task automatic run_kernel(input logic [7:0] g, input logic [7:0] d, input bit disturb);
        int cyc;
        model_run(g, d);
        @(negedge clk);
        gamma_list = g; dir_bits = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0; gamma_list = ~g; dir_bits = ~d;
        cyc = 0;
        while (busy && cyc < 100) begin
            cyc++;
            if (disturb && cyc == 3) begin
                ld_en = 1'b1; ld_addr = 4'd0; ld_data = 8'hEE; start = 1'b1;
            end else begin
                ld_en = 1'b0; start = 1'b0;
            end
            @(negedge clk);
        end
        ld_en = 1'b0; start = 1'b0;
        chk(disturb ? "R8 run length with mid-run start/load" : "R3 busy length", cyc, RUN_CYC);
        chk("R3 done at end", int'(done), 1);
        @(negedge clk);
        chk("R3 done one cycle", int'(done), 0);
    endtask

    task automatic compare_all(input string req);
        logic [7:0] v;
        for (int a = 0; a < WORDS; a++) begin
            read_word(a, v);
            chk(req, int'(v), int'(model[a]));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        rst = 1'b1; ld_en = 1'b0; ld_addr = '0; ld_data = '0; rd_addr = '0;
        start = 1'b0; gamma_list = '0; dir_bits = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 done after reset", int'(done), 0);
        for (int a = 0; a < WORDS; a++) begin
            read_word(a, v);
            chk("R1 word zero", int'(v), 0);
            model[a] = 8'h00;
        end

        // R2: load then read back
        for (int a = 0; a < WORDS; a++) load_word(a, 8'(a * 17 + 3));
        compare_all("R2 load/read");

        // R5: pair 7 at bit 1 uses words 13 and 15 (ascending)
        for (int a = 0; a < WORDS; a++) load_word(a, 8'h00);
        load_word(13, 8'd9);
        load_word(15, 8'd3);
        run_kernel(8'h55, 8'h00, 1'b0);
        read_word(13, v); chk("R5 word 13 gets smaller", int'(v), 3);
        read_word(15, v); chk("R5 word 15 gets larger", int'(v), 9);

        // R6: descending keeps larger at lower address
        run_kernel(8'h55, 8'hFF, 1'b0);
        read_word(13, v); chk("R6 descending lower", int'(v), 9);
        read_word(15, v); chk("R6 descending upper", int'(v), 3);
        compare_all("R6 descending all words");

        // R6: equal words untouched
        load_word(2, 8'd5); load_word(3, 8'd5);
        run_kernel(8'h00, 8'h0F, 1'b0);
        compare_all("R6 equal words");

        // R9: bitonic merge with positions 3,2,1,0 ascending
        for (int a = 0; a < 8; a++) load_word(a, 8'(2 * a + 1));
        for (int a = 8; a < 16; a++) load_word(a, 8'(2 * (15 - a)));
        run_kernel(8'h1B, 8'h00, 1'b0);
        for (int a = 0; a < WORDS; a++) begin
            read_word(a, v);
            chk("R9 sorted ascending", int'(v), a);
        end

        // R8: load and start during a run are ignored
        for (int a = 0; a < WORDS; a++) load_word(a, next_rand());
        run_kernel(8'h1B, 8'h3C, 1'b1);
        compare_all("R8 mid-run load ignored");

        // R4 R5 R6 R7: sweep every position list with varied directions and data
        for (int g = 0; g < 256; g++) begin
            for (int a = 0; a < WORDS; a++) load_word(a, next_rand());
            run_kernel(8'(g), 8'(g * 37) ^ 8'h5A, (g % 16) == 5);
            compare_all("R4 R5 R6 R7 sweep result");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule